// File: doc/BRIEF.md
# Double-Buffered Byte Loader for a Serial Configuration Stream

This block sits between a microprocessor-style write bus and a serial configuration sink. The bus master selects the block with two chip selects of opposite polarity, puts a byte on the data bus and pulses the active-low write strobe. On the trailing (rising) edge of that strobe the byte is latched into a holding register. From there it moves into a shift register, which sends it out one bit per clock, most significant bit first, with a valid strobe beside the data bit.

Because there are two registers, the master can post a second byte while the first is still being shifted out. A ready output tells the master when the holding register is free again. How long ready stays low depends on whether the shifter was idle or busy when the byte arrived. The ready flag can also be read back on the top data bit. With the block selected, write high and read low, the block enables a driver for bit 7 only, and the other data bits stay inputs. The bus strobes are asynchronous to the block clock and pass through a synchronizer. A write made while ready is low is dropped and recorded in a sticky overrun flag.

Top module: `cfg_byte_loader`

## Requirements
- R1: While reset is held and on the first cycle after it, `rdy` is 1 and `ser_valid`, `overrun` and `top_bit_oe` are 0.
- R2: A write strobe has no effect unless `cs_n` is 0 and `cs` is 1 at the same time: with only one select asserted, no serial output appears and `rdy` stays 1.
- R3: A selected write captures `din` on the rising edge of `wr_n` and then drives `rdy` low. The selects may be released between bytes or held asserted across several bytes.
- R4: When the shifter is idle, a captured byte moves into it on the next clock, so `rdy` is low for exactly one clock.
- R5: Each byte leaves on `ser_data` most significant bit first, with `ser_valid` high for exactly 8 consecutive clocks.
- R6: A byte captured while the shifter is busy waits in the holding register, and `rdy` stays low until the current byte has fully shifted out. The held byte loads on the clock after the last bit, which leaves exactly one idle `ser_valid` cycle between the two bytes.
- R7: `top_bit_oe` is 1 only while both selects are asserted, `wr_n` is 1 and `rd_n` is 0. While it is 1, `top_bit_out` carries the `rdy` value. No other data bit has a driver.
- R8: A selected write made while `rdy` is 0 is ignored, leaving no trace in the serial stream, and sets `overrun` to 1. `overrun` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| cs | input | 1 | Active-high chip select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe; byte taken on its rising edge |
| rd_n | input | 1 | Active-low read strobe; enables the bit-7 status driver |
| din | input | DW | Byte from the bus |
| rdy | output | 1 | High when the holding register can take a byte |
| top_bit_out | output | 1 | Ready value for the top data bit during a read |
| top_bit_oe | output | 1 | Output enable for the top data bit |
| ser_data | output | 1 | Serial configuration bit |
| ser_valid | output | 1 | Qualifies `ser_data` |
| overrun | output | 1 | Sticky flag: a write arrived while not ready |

## Verification
Two functions can meet in the same clock. One is a new byte landing in the holding register while the shifter is still emitting an earlier byte. The other is a further write arriving while a held byte is waiting for that shifter. The bench provokes both by issuing writes with one-clock strobes back to back, so the second byte arrives a few clocks into the first byte's shift and the third arrives while the second is still held. It then judges the serial stream captured at the output: exact byte values, MSB-first order, a single idle cycle before the held byte, no trace of the dropped byte, and the overrun flag staying set.

// File: rtl/abl_pkg.sv
package abl_pkg;

  // Bus control pins after synchronization, packed so one synchronizer carries them all
  typedef struct packed {
    logic cs_n;
    logic cs;
    logic wr_n;
    logic rd_n;
  } bus_ctl_t;

  localparam int CTL_W = $bits(bus_ctl_t);

  // Idle level of each control pin: deselected, no strobe
  localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, cs: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

endpackage

// File: rtl/abl_sync.sv
module abl_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/abl_hold_shift.sv
module abl_hold_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          rdy_o,
  output logic          ser_data_o,
  output logic          ser_valid_o
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          hold_full;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] shift_q;
  logic [CW-1:0] cnt;
  logic          shifting;
  logic          last;

  assign last  = (cnt == LAST_BIT);
  assign rdy_o = !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full   <= 1'b0;
      hold_q      <= '0;
      shift_q     <= '0;
      cnt         <= '0;
      shifting    <= 1'b0;
      ser_data_o  <= 1'b0;
      ser_valid_o <= 1'b0;
    end else begin
      ser_valid_o <= shifting;
      ser_data_o  <= shift_q[DW-1];
      if (shifting) begin
        shift_q <= shift_q << 1;
        cnt     <= cnt + 1'b1;
        if (last) shifting <= 1'b0;
      end else if (hold_full) begin
        shift_q   <= hold_q;
        shifting  <= 1'b1;
        cnt       <= '0;
        hold_full <= 1'b0;
      end
      if (load_i && !hold_full) begin
        hold_full <= 1'b1;
        hold_q    <= data_i;
      end
    end
  end

  AST_MOVE_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !shifting) |=> (shifting && !hold_full)); // R4

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (hold_full && shifting) |=> hold_full); // R6

  AST_EIGHT_BITS: assert property (@(posedge clk) disable iff (rst)
    $fell(shifting) |-> ($past(cnt) == LAST_BIT)); // R5

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import abl_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic          rdy,
  output logic          top_bit_out,
  output logic          top_bit_oe,
  output logic          ser_data,
  output logic          ser_valid,
  output logic          overrun
);

  logic [CTL_W-1:0] ctl_raw;
  bus_ctl_t         ctl;
  logic [DW-1:0]    din_s;
  logic             wr_prev;
  logic             selected;
  logic             wr_rise;
  logic             strobe;
  logic             load;

  abl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, cs, wr_n, rd_n}),
    .q   (ctl_raw)
  );

  abl_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (din_s)
  );

  assign ctl      = bus_ctl_t'(ctl_raw);
  assign selected = !ctl.cs_n && ctl.cs;
  assign wr_rise  = ctl.wr_n && !wr_prev;
  assign strobe   = wr_rise && selected;
  assign load     = strobe && rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev     <= 1'b1;
      overrun     <= 1'b0;
      top_bit_oe  <= 1'b0;
      top_bit_out <= 1'b0;
    end else begin
      wr_prev     <= ctl.wr_n;
      if (strobe && !rdy) overrun <= 1'b1;
      top_bit_oe  <= selected && ctl.wr_n && !ctl.rd_n;
      top_bit_out <= rdy;
    end
  end

  abl_hold_shift #(.DW(DW)) u_hold_shift (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .data_i      (din_s),
    .rdy_o       (rdy),
    .ser_data_o  (ser_data),
    .ser_valid_o (ser_valid)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (rdy && !ser_valid && !overrun && !top_bit_oe)); // R1

  AST_ACCEPT_DROPS_RDY: assert property (@(posedge clk) disable iff (rst)
    load |=> !rdy); // R3

  AST_D7_TRACKS_RDY: assert property (@(posedge clk) disable iff (rst)
    top_bit_oe |-> (top_bit_out == $past(rdy))); // R7

  AST_OE_NEEDS_WR_HIGH: assert property (@(posedge clk) disable iff (rst)
    top_bit_oe |-> $past(ctl.wr_n && !ctl.rd_n)); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R8

endmodule

// File: tb/cfg_byte_loader_bench.sv
`timescale 1ns/1ps
module cfg_byte_loader_bench;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, cs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic rdy, top_bit_out, top_bit_oe, ser_data, ser_valid, overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Serial monitor state
  logic [DW-1:0] acc = '0;
  int nb = 0;
  int idle_run = 0;
  logic [DW-1:0] rx [32];
  int gaps [32];
  int rx_n = 0;

  always #5 clk = ~clk;

  cfg_byte_loader #(.DW(DW)) u_cfg_byte_loader (
    .clk (clk), .rst (rst), .cs_n (cs_n), .cs (cs), .wr_n (wr_n), .rd_n (rd_n),
    .din (din), .rdy (rdy), .top_bit_out (top_bit_out), .top_bit_oe (top_bit_oe),
    .ser_data (ser_data), .ser_valid (ser_valid), .overrun (overrun)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_valid) begin
        if (nb == 0) begin
          if (rx_n < 32) gaps[rx_n] = idle_run;
          idle_run = 0;
        end
        acc = {acc[DW-2:0], ser_data};
        nb++;
        if (nb == DW) begin
          if (rx_n < 32) rx[rx_n] = acc;
          rx_n++;
          nb = 0;
        end
      end else begin
        idle_run++;
        if (nb != 0) begin
          errors++;
          $display("FAIL R5: valid dropped after %0d bits, expected %0d", nb, DW);
          nb = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [DW-1:0] b, input logic sn, input logic sp, input int nlow);
    @(negedge clk);
    din = b; cs_n = sn; cs = sp; wr_n = 1'b0;
    wait_n(nlow);
    wr_n = 1'b1;
  endtask

  task automatic deselect();
    @(negedge clk);
    cs_n = 1'b1; cs = 1'b0; rd_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(rdy == 1'b1, "R1 rdy", rdy, 1);
    chk(ser_valid == 1'b0, "R1 ser_valid", ser_valid, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(top_bit_oe == 1'b0, "R1 oe", top_bit_oe, 0);
  endtask

  task automatic t_select();
    int base = rx_n;
    int lows = 0;
    bus_write(8'hA5, 1'b1, 1'b1, 2);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (!rdy) lows++; end
    deselect();
    bus_write(8'h96, 1'b0, 1'b0, 2);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (!rdy) lows++; end
    deselect();
    wait_n(20);
    chk(rx_n == base, "R2 no bytes", rx_n - base, 0);
    chk(lows == 0, "R2 rdy stays high", lows, 0);
  endtask

  task automatic t_empty();
    int base = rx_n;
    int lows = 0;
    bus_write(8'hC3, 1'b0, 1'b1, 2);
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (!rdy) lows++; end
    chk(lows == 1, "R4 one-cycle rdy low", lows, 1);
    wait_n(15);
    // R3: selects held, second byte
    bus_write(8'h5A, 1'b0, 1'b1, 3);
    wait_n(3);
    deselect();
    wait_n(15);
    chk(rx_n == base + 2, "R3 byte count", rx_n - base, 2);
    chk(rx[base] == 8'hC3, "R5 first byte msb-first", rx[base], 8'hC3);
    chk(rx[base+1] == 8'h5A, "R3 held selects byte", rx[base+1], 8'h5A);
    // R3: toggled selects between bytes
    bus_write(8'h01, 1'b0, 1'b1, 2);
    wait_n(3);
    deselect();
    wait_n(15);
    chk(rx[base+2] == 8'h01, "R3 toggled selects byte", rx[base+2], 8'h01);
  endtask

  task automatic t_busy();
    int base = rx_n;
    bus_write(8'h81, 1'b0, 1'b1, 1);
    bus_write(8'h3C, 1'b0, 1'b1, 1);
    wait_n(3);
    chk(rdy == 1'b0, "R6 rdy low while held", rdy, 0);
    wait_n(3);
    chk(rdy == 1'b0, "R6 rdy still low", rdy, 0);
    deselect();
    wait_n(25);
    chk(rx_n == base + 2, "R6 byte count", rx_n - base, 2);
    chk(rx[base] == 8'h81, "R6 first byte", rx[base], 8'h81);
    chk(rx[base+1] == 8'h3C, "R6 held byte", rx[base+1], 8'h3C);
    chk(gaps[base+1] == 1, "R6 one idle cycle", gaps[base+1], 1);
    chk(overrun == 1'b0, "R6 no overrun", overrun, 0);
  endtask

  task automatic t_read();
    int base = rx_n;
    @(negedge clk);
    cs_n = 1'b0; cs = 1'b1; rd_n = 1'b0;
    wait_n(4);
    chk(top_bit_oe == 1'b1, "R7 oe on read", top_bit_oe, 1);
    chk(top_bit_out == 1'b1, "R7 d7 ready idle", top_bit_out, 1);
    @(negedge clk);
    rd_n = 1'b1;
    wait_n(4);
    chk(top_bit_oe == 1'b0, "R7 oe off", top_bit_oe, 0);
    deselect();
    bus_write(8'hE7, 1'b0, 1'b1, 1);
    bus_write(8'h18, 1'b0, 1'b1, 1);
    @(negedge clk);
    rd_n = 1'b0;
    wait_n(3);
    chk(top_bit_oe == 1'b1, "R7 oe while busy", top_bit_oe, 1);
    chk(top_bit_out == 1'b0, "R7 d7 not ready", top_bit_out, 0);
    @(negedge clk);
    cs = 1'b0;
    wait_n(4);
    chk(top_bit_oe == 1'b0, "R7 oe needs select", top_bit_oe, 0);
    deselect();
    wait_n(25);
    chk(rx_n == base + 2, "R7 read adds no bytes", rx_n - base, 2);
  endtask

  task automatic t_overrun();
    int base = rx_n;
    bus_write(8'hF0, 1'b0, 1'b1, 1);
    bus_write(8'h0F, 1'b0, 1'b1, 1);
    bus_write(8'hAA, 1'b0, 1'b1, 1);
    wait_n(4);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    deselect();
    wait_n(30);
    chk(rx_n == base + 2, "R8 dropped byte absent", rx_n - base, 2);
    chk(rx[base+1] == 8'h0F, "R8 held byte kept", rx[base+1], 8'h0F);
    bus_write(8'h66, 1'b0, 1'b1, 2);
    wait_n(3);
    deselect();
    wait_n(15);
    chk(rx[base+2] == 8'h66, "R8 later write accepted", rx[base+2], 8'h66);
    chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_empty();
    t_busy();
    t_read();
    t_overrun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule